// File: doc/BRIEF.md
# Row-Primitive Compare-and-Swap Array

This block models a small SRAM-style compute array in which every logic operation acts on whole rows. One in-array operation senses two source rows at once and writes their bitwise NOR or bitwise AND into a destination row. A sense option can also take one column of the second source and replicate that single bit across the row width. A fixed microprogram, stepped by a small sequencer, uses only these primitives. It compares two unsigned operands most-significant bit first and then routes the smaller value and the larger value to two result rows through a row-level multiplexer.

The host loads operand A into row 3 and operand B into row 4 through a simple write port, then pulses `start`. While the sequence runs, `busy` is high. One cycle after the final write, `done` pulses and the host reads the minimum from row 5 and the maximum from row 6. Row 0 holds all zeros and row 1 holds all ones. These two constant rows supply NOT (NOR with row 0) and copy (AND with row 1). Rows 7 to 15 are scratch space for the microprogram.

Top module: `rowcas_engine`

## Requirements
- R1: After reset, `busy` and `done` are low, row 0 reads as all zeros, row 1 reads as all ones, and every other row reads as zero.
- R2: While idle, a host write (`host_we` high at a clock edge) to any row from 2 to 15 stores `host_wdata`. `host_rdata` combinationally shows the row selected by `host_addr`.
- R3: Host writes to row 0 or row 1 have no effect. These rows keep all zeros and all ones respectively.
- R4: A `start` pulse sampled while idle raises `busy` in the next cycle. `done` is high for exactly one cycle, 4*W+11 cycles after the start edge (27 cycles for W=4), and `busy` falls at the same edge.
- R5: When `done` is seen, row 5 holds the unsigned minimum of the values in rows 3 and 4, and row 6 holds the unsigned maximum.
- R6: When the two operands are equal, no swap takes place and rows 5 and 6 both hold that value.
- R7: A sort leaves rows 3 and 4 unchanged.
- R8: A `start` pulse sampled while `busy` is high is ignored. The running sort keeps its original `done` timing and its results, and no second sort follows.
- R9: Host writes sampled while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a compare-and-swap when idle |
| busy | output | 1 | High while the microprogram runs |
| done | output | 1 | One-cycle pulse after the last result write |
| host_we | input | 1 | Host row write enable |
| host_addr | input | 4 | Row address for host write and read |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Contents of the addressed row |

## Verification
Every pair of 4-bit operands is sorted, 256 runs in all. This separates the branch where A is larger (swap), the branch where B is larger (pass-through) and the equal case. It also exercises each bit position as the deciding bit of the most-significant-first chain, so an error in the precedence of the equal and greater terms shows up as a wrong minimum or maximum. Each run also checks the done latency and that the operands are preserved. Separate runs inject a second `start` and an operand overwrite in the middle of a sort, and confirm that neither changes the timing or the results. Writes aimed at the constant rows are checked by reading those rows back.

// File: rtl/rowcas_pkg.sv
package rowcas_pkg;

   localparam int unsigned ROW_AW  = 4;
   localparam int unsigned NROWS   = 2 ** ROW_AW;
   localparam int unsigned LANE_AW = 8;

   typedef logic [ROW_AW-1:0] row_t;

   localparam row_t R_ZERO = 4'd0;
   localparam row_t R_ONE  = 4'd1;
   localparam row_t R_A    = 4'd3;
   localparam row_t R_B    = 4'd4;
   localparam row_t R_MIN  = 4'd5;
   localparam row_t R_MAX  = 4'd6;
   localparam row_t R_NA   = 4'd7;
   localparam row_t R_NB   = 4'd8;
   localparam row_t R_GT   = 4'd9;
   localparam row_t R_EQ   = 4'd10;
   localparam row_t R_T    = 4'd11;
   localparam row_t R_GF   = 4'd12;
   localparam row_t R_EF   = 4'd13;
   localparam row_t R_NSEL = 4'd14;
   localparam row_t R_T2   = 4'd15;

   typedef enum logic {OP_NOR = 1'b0, OP_AND = 1'b1} rowop_e;

   typedef struct packed {
      rowop_e             op;
      row_t               dst;
      row_t               srca;
      row_t               srcb;
      logic               spread;
      logic [LANE_AW-1:0] lane;
   } instr_t;

   function automatic int unsigned prog_len(int unsigned w);
      return 4 * w + 11;
   endfunction

   function automatic instr_t mk(rowop_e op, row_t d, row_t a, row_t b,
                                 logic sp, int unsigned ln);
      instr_t s;
      s.op     = op;
      s.dst    = d;
      s.srca   = a;
      s.srcb   = b;
      s.spread = sp;
      s.lane   = LANE_AW'(ln);
      return s;
   endfunction

   // Microprogram: per-bit terms, MSB-first chain, then row-level mux.
   function automatic instr_t ucode_step(int unsigned pc, int unsigned w);
      int unsigned tail, j, r, k;
      instr_t s;
      tail = 4 * w + 2;
      s = mk(OP_AND, R_T, R_ONE, R_ONE, 1'b0, 0);
      if (pc == 0)      s = mk(OP_NOR, R_NA, R_A,  R_ZERO, 1'b0, 0);
      else if (pc == 1) s = mk(OP_NOR, R_NB, R_B,  R_ZERO, 1'b0, 0);
      else if (pc == 2) s = mk(OP_AND, R_GT, R_A,  R_NB,   1'b0, 0);
      else if (pc == 3) s = mk(OP_AND, R_T,  R_NA, R_B,    1'b0, 0);
      else if (pc == 4) s = mk(OP_NOR, R_EQ, R_GT, R_T,    1'b0, 0);
      else if (pc == 5) s = mk(OP_AND, R_GF, R_ONE, R_GT,  1'b1, w - 1);
      else if (pc == 6) s = mk(OP_AND, R_EF, R_ONE, R_EQ,  1'b1, w - 1);
      else if (pc < tail) begin
         j = (pc - 7) / 4;
         r = (pc - 7) % 4;
         k = w - 2 - j;
         case (r)
            0:       s = mk(OP_AND, R_T,  R_EF, R_GT,   1'b1, k);
            1:       s = mk(OP_NOR, R_T2, R_GF, R_T,    1'b0, 0);
            2:       s = mk(OP_NOR, R_GF, R_T2, R_ZERO, 1'b0, 0);
            default: s = mk(OP_AND, R_EF, R_EF, R_EQ,   1'b1, k);
         endcase
      end else begin
         case (pc - tail)
            0:       s = mk(OP_NOR, R_NSEL, R_GF, R_ZERO, 1'b0, 0);
            1:       s = mk(OP_AND, R_T,    R_B,  R_GF,   1'b0, 0);
            2:       s = mk(OP_AND, R_T2,   R_A,  R_NSEL, 1'b0, 0);
            3:       s = mk(OP_NOR, R_T,    R_T,  R_T2,   1'b0, 0);
            4:       s = mk(OP_NOR, R_MIN,  R_T,  R_ZERO, 1'b0, 0);
            5:       s = mk(OP_AND, R_T,    R_A,  R_GF,   1'b0, 0);
            6:       s = mk(OP_AND, R_T2,   R_B,  R_NSEL, 1'b0, 0);
            7:       s = mk(OP_NOR, R_T,    R_T,  R_T2,   1'b0, 0);
            default: s = mk(OP_NOR, R_MAX,  R_T,  R_ZERO, 1'b0, 0);
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/rowcas_ucode.sv
module rowcas_ucode
   import rowcas_pkg::*;
#(
   parameter int unsigned W    = 4,
   parameter int unsigned PC_W = 5
) (
   input  logic [PC_W-1:0] pc,
   output instr_t          step
);

   initial begin
      if (W < 2 || W > 2 ** LANE_AW)
         $error("rowcas_ucode: W out of range");
      if (2 ** PC_W < prog_len(W))
         $error("rowcas_ucode: PC_W too narrow");
   end

   always_comb step = ucode_step(int'(pc), W);

endmodule

// File: rtl/rowcas_array.sv
module rowcas_array
   import rowcas_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         exec_en,
   input  instr_t       step,
   input  logic         wr_en,
   input  row_t         wr_addr,
   input  logic [W-1:0] wr_data,
   input  row_t         rd_addr,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] min_q,
   output logic [W-1:0] max_q
);

   localparam int unsigned LW = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0] rows [NROWS];
   logic [W-1:0] src_a, src_b_raw, src_b, result;
   logic [W-1:0] a_q, b_q;
   logic [LANE_AW-LW-1:0] lane_hi_unused;

   always_comb begin
      src_a     = rows[step.srca];
      src_b_raw = rows[step.srcb];
      src_b     = step.spread ? {W{src_b_raw[step.lane[LW-1:0]]}} : src_b_raw;
      result    = (step.op == OP_AND) ? (src_a & src_b) : ~(src_a | src_b);
   end

   assign lane_hi_unused = step.lane[LANE_AW-1:LW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NROWS; i++)
            rows[i] <= (i == int'(R_ONE)) ? '1 : '0;
      end else if (exec_en) begin
         if (step.dst > R_ONE) rows[step.dst] <= result;
      end else if (wr_en && wr_addr > R_ONE) begin
         rows[wr_addr] <= wr_data;
      end
   end

   assign rd_data = rows[rd_addr];
   assign min_q   = rows[R_MIN];
   assign max_q   = rows[R_MAX];
   assign a_q     = rows[R_A];
   assign b_q     = rows[R_B];

   // R3
   const_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rows[R_ZERO] == '0) && (rows[R_ONE] == '1));

   // R7
   operand_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/rowcas_engine.sv
module rowcas_engine
   import rowcas_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                busy,
   output logic                done,
   input  logic                host_we,
   input  logic [ROW_AW-1:0]   host_addr,
   input  logic [W-1:0]        host_wdata,
   output logic [W-1:0]        host_rdata
);

   localparam int unsigned NSTEP = prog_len(W);
   localparam int unsigned PC_W  = $clog2(NSTEP);

   logic [PC_W-1:0] pc;
   logic            last;
   instr_t          step;
   logic [W-1:0]    min_q, max_q;

   assign last = (pc == PC_W'(NSTEP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         pc   <= '0;
      end else begin
         done <= busy && last;
         if (busy) begin
            pc   <= last ? '0 : pc + 1'b1;
            busy <= !last;
         end else if (start) begin
            busy <= 1'b1;
            pc   <= '0;
         end
      end
   end

   rowcas_ucode #(.W(W), .PC_W(PC_W)) i_ucode (
      .pc   (pc),
      .step (step)
   );

   rowcas_array #(.W(W)) i_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec_en (busy),
      .step    (step),
      .wr_en   (host_we && !busy),
      .wr_addr (host_addr),
      .wr_data (host_wdata),
      .rd_addr (host_addr),
      .rd_data (host_rdata),
      .min_q   (min_q),
      .max_q   (max_q)
   );

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R8
   busy_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && pc == $past(pc) + 1'b1));

   // R5
   result_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (min_q <= max_q));

endmodule

// File: tb/test_rowcas_engine.sv
module test_rowcas_engine;

   localparam int W     = 4;
   localparam int NSTEP = 4 * W + 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         busy, done;
   logic         host_we = 1'b0;
   logic [3:0]   host_addr = '0;
   logic [W-1:0] host_wdata = '0;
   logic [W-1:0] host_rdata;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rowcas_engine #(.W(W)) i_rowcas_engine (
      .clk, .rst_n, .start, .busy, .done,
      .host_we, .host_addr, .host_wdata, .host_rdata
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      host_we = 1'b1; host_addr = 4'(addr); host_wdata = W'(data);
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(int addr, output int data);
      host_addr = 4'(addr);
      #0.5;
      data = int'(host_rdata);
   endtask

   // mode 0 plain, 1 extra start mid-run, 2 host write to row 3 mid-run
   task automatic sort_run(int a, int b, int mode);
      int cnt, v, lo, hi;
      wr(3, a);
      wr(4, b);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R4 busy after start", int'(busy), 1);
      cnt = 0;
      while (cnt < 100) begin
         @(negedge clk);
         cnt++;
         if (mode == 1) start = (cnt == 5);
         if (mode == 2) begin
            host_we = (cnt == 5); host_addr = 4'd3; host_wdata = W'(~a);
         end
         if (done) break;
      end
      start = 1'b0; host_we = 1'b0;
      chk("R4 done latency", cnt, NSTEP);
      chk("R4 busy low with done", int'(busy), 0);
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      rd(5, v); chk((a == b) ? "R6 min equal" : "R5 min", v, lo);
      rd(6, v); chk((a == b) ? "R6 max equal" : "R5 max", v, hi);
      rd(3, v); chk((mode == 2) ? "R9 row3 kept" : "R7 row3 kept", v, a);
      rd(4, v); chk("R7 row4 kept", v, b);
      @(negedge clk);
      chk("R4 done one cycle", int'(done), 0);
      if (mode == 1) begin
         repeat (NSTEP + 3) begin
            @(negedge clk);
            chk("R8 no second run", int'(busy | done), 0);
         end
      end
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      rd(0, v); chk("R1 row0", v, 0);
      rd(1, v); chk("R1 row1", v, (1 << W) - 1);
      for (int r = 2; r < 16; r++) begin
         rd(r, v); chk("R1 other rows", v, 0);
      end
      for (int r = 2; r < 16; r++) begin
         wr(r, (r * 7) & ((1 << W) - 1));
         rd(r, v); chk("R2 write readback", v, (r * 7) & ((1 << W) - 1));
      end
      wr(0, (1 << W) - 1);
      rd(0, v); chk("R3 row0 protected", v, 0);
      wr(1, 0);
      rd(1, v); chk("R3 row1 protected", v, (1 << W) - 1);
      for (int a = 0; a < (1 << W); a++)
         for (int b = 0; b < (1 << W); b++)
            sort_run(a, b, 0);
      sort_run(9, 3, 1);
      sort_run(2, 12, 1);
      sort_run(11, 6, 2);
      sort_run(5, 5, 2);
      rd(0, v); chk("R3 row0 after sorts", v, 0);
      rd(1, v); chk("R3 row1 after sorts", v, (1 << W) - 1);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1;
      rst_n = 1'b0;
      #11;
      rst_n = 1'b1;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule